// File: doc/BRIEF.md
# Cipher Frame Counter Scheduler

This block keeps the per-frame counter that holds a link cipher in step between the sending and the receiving end of a protected video link. It watches frame-start pulses and decides, from the frame's encryption flag, the mute state, the link mode (DVI or HDMI) and an optional advance-always setting, whether the counter moves on. Each time it does, the block raises an advance strobe for the cipher. It also raises two periodic strobes: one telling the link-check logic to refresh its 16-bit check value, and one telling the pixel-check logic to capture a sample.

The scheduler is idle after reset. An authentication-done pulse clears the counter and arms it. The first encrypted, unmuted frame after that loads the counter with 1, and counting goes on from there. A muted HDMI link freezes the counter. Once the mute is released, only an encrypted frame restarts counting, even when the advance-always setting is on.

Top module: `link_frame_sched`

## Requirements
- R1: After synchronous reset, and until the first authentication-done pulse, the count is 0, every strobe is low, and frame-start pulses have no effect.
- R2: After authentication-done, frames that are unencrypted or muted leave the count at 0, even with advance-always on. The first encrypted, unmuted frame sets the count to 1 and raises the advance strobe.
- R3: With advance-always off, the count rises by one only on frames whose encryption flag is 1.
- R4: With advance-always on in DVI mode (mode select 0), every frame advances the count. The mute flag is ignored.
- R5: With advance-always on in HDMI mode (mode select 1), every frame that is not muted advances the count, whether it is encrypted or not.
- R6: In HDMI mode, a frame seen while mute is 1 never advances the count. After mute has been seen, the next advance happens only on an encrypted, unmuted frame. Ordinary rules apply after that advance.
- R7: The link-check strobe fires together with the advance strobe exactly when the new count is a non-zero multiple of 128. The first firing is at count 128.
- R8: The pixel-check strobe fires together with the advance strobe exactly when the new count is a non-zero multiple of 16.
- R9: An authentication-done pulse clears the count to 0 and re-arms the block. It takes priority over a frame-start pulse in the same cycle, and that frame produces no strobe.
- R10: The count wraps from all ones to 0. That advance raises the advance strobe but neither periodic strobe.
- R11: Count and strobes change one clock after the cycle in which the frame-start pulse is high. Each strobe lasts one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| frame_enc | input | 1 | Current frame is encrypted |
| mute | input | 1 | Audio/video mute is active (used only in HDMI mode) |
| hdmi_mode | input | 1 | 1 = HDMI mode, 0 = DVI mode |
| adv_en | input | 1 | Advance-always setting |
| auth_done | input | 1 | One-cycle pulse when authentication completes |
| frame_cnt | output | CNT_W | Current frame count |
| adv_stb | output | 1 | Cipher advance strobe |
| link_stb | output | 1 | 16-bit link-check update strobe (every 128 counts) |
| pix_stb | output | 1 | Pixel-check capture strobe (every 16 counts) |

## Verification
A wrong decision on whether a frame advances shows up on the count one clock after that frame's start pulse. From then on, every later count is off by one, and the periodic strobes land on the wrong frames. A mute-hold flag that stays stuck or clears too early shows only on the frame after an HDMI mute, as an advance on an unencrypted frame or a missing advance on an encrypted one. A missing guard at the wrap shows only on the single frame where the count returns to 0. It is caught there with a narrow-counter instance.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } lfs_state_e;

  // One-cycle command from the controller to the counter
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } lfs_cmd_t;

endpackage

// File: rtl/lfs_ctrl.sv
module lfs_ctrl
  import lfs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frame_start,
  input  logic     frame_enc,
  input  logic     mute,
  input  logic     hdmi_mode,
  input  logic     adv_en,
  input  logic     auth_done,
  output lfs_cmd_t cmd
);

  lfs_state_e state_q;
  logic       hold_q;   // set once mute is seen; wait for an encrypted frame
  logic       muted;

  assign muted = hdmi_mode & mute;

  always_comb begin
    cmd = '0;
    if (auth_done) begin
      cmd.clear = 1'b1;
    end else if (frame_start && !muted) begin
      unique case (state_q)
        ST_ARMED: cmd.load = frame_enc;
        ST_RUN: begin
          if (hold_q)      cmd.step = frame_enc;
          else if (adv_en) cmd.step = 1'b1;
          else             cmd.step = frame_enc;
        end
        default: cmd = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b0;
    end else if (auth_done) begin
      state_q <= ST_ARMED;
      hold_q  <= 1'b0;
    end else begin
      if (cmd.load) state_q <= ST_RUN;
      if (state_q == ST_RUN && muted) hold_q <= 1'b1;
      else if (cmd.step)              hold_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lfs_counter.sv
module lfs_counter
  import lfs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  lfs_cmd_t         cmd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             fire,
  output logic             adv_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign fire = cmd.load | cmd.step;

  always_comb begin
    if (cmd.clear)     cnt_nxt = '0;
    else if (cmd.load) cnt_nxt = ONE;
    else if (cmd.step) cnt_nxt = cnt_q + ONE;
    else               cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      adv_q <= fire;
    end
  end

endmodule

// File: rtl/lfs_tap.sv
module lfs_tap #(
  parameter int CNT_W = 32,
  parameter int LOG2  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             stb_q
);

  logic on_period;

  // a zero count is the wrap, not a period boundary
  assign on_period = (cnt_nxt[LOG2-1:0] == '0) && (cnt_nxt != '0);

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= fire & on_period;
  end

endmodule

// File: rtl/link_frame_sched.sv
module link_frame_sched
  import lfs_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int LINK_LOG2 = 7,
  parameter int PIX_LOG2  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             frame_enc,
  input  logic             mute,
  input  logic             hdmi_mode,
  input  logic             adv_en,
  input  logic             auth_done,
  output logic [CNT_W-1:0] frame_cnt,
  output logic             adv_stb,
  output logic             link_stb,
  output logic             pix_stb
);

  localparam int NTAP = 2;
  localparam int TAP_LOG2 [NTAP] = '{LINK_LOG2, PIX_LOG2};

  lfs_cmd_t         cmd;
  logic [CNT_W-1:0] cnt_nxt;
  logic             fire;
  logic [NTAP-1:0]  tap_stb;

  lfs_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .frame_enc  (frame_enc),
    .mute       (mute),
    .hdmi_mode  (hdmi_mode),
    .adv_en     (adv_en),
    .auth_done  (auth_done),
    .cmd        (cmd)
  );

  lfs_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .cnt_q  (frame_cnt),
    .cnt_nxt(cnt_nxt),
    .fire   (fire),
    .adv_q  (adv_stb)
  );

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    lfs_tap #(.CNT_W(CNT_W), .LOG2(TAP_LOG2[g])) u_tap (
      .clk    (clk),
      .rst    (rst),
      .fire   (fire),
      .cnt_nxt(cnt_nxt),
      .stb_q  (tap_stb[g])
    );
  end

  assign link_stb = tap_stb[0];
  assign pix_stb  = tap_stb[1];

endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
  parameter int CNT_W     = 32,
  parameter int LINK_LOG2 = 7,
  parameter int PIX_LOG2  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             mute,
  input logic             hdmi_mode,
  input logic             auth_done,
  input logic [CNT_W-1:0] frame_cnt,
  input logic             adv_stb,
  input logic             link_stb,
  input logic             pix_stb
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (frame_cnt == '0 && !adv_stb && !link_stb && !pix_stb)); // R1

  AST_QUIET_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !auth_done) |=> ($stable(frame_cnt) && !adv_stb)); // R11

  AST_MUTE_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (frame_start && hdmi_mode && mute && !auth_done) |=> ($stable(frame_cnt) && !adv_stb)); // R6

  AST_AUTH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    auth_done |=> (frame_cnt == '0 && !adv_stb)); // R9

  AST_ADVANCE_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    adv_stb |-> (frame_cnt == CNT_W'($past(frame_cnt) + 1'b1) || frame_cnt == CNT_W'(1))); // R3

  AST_LINK_ON_PERIOD: assert property (@(posedge clk) disable iff (rst)
    link_stb |-> (adv_stb && pix_stb && frame_cnt[LINK_LOG2-1:0] == '0)); // R7

  AST_PIX_ON_PERIOD: assert property (@(posedge clk) disable iff (rst)
    pix_stb |-> (adv_stb && frame_cnt[PIX_LOG2-1:0] == '0)); // R8

  AST_NO_WRAP_STROBE: assert property (@(posedge clk) disable iff (rst)
    (link_stb || pix_stb) |-> (frame_cnt != '0)); // R10

endmodule

bind link_frame_sched lfs_checker #(
  .CNT_W    (CNT_W),
  .LINK_LOG2(LINK_LOG2),
  .PIX_LOG2 (PIX_LOG2)
) u_lfs_checker (
  .clk        (clk),
  .rst        (rst),
  .frame_start(frame_start),
  .mute       (mute),
  .hdmi_mode  (hdmi_mode),
  .auth_done  (auth_done),
  .frame_cnt  (frame_cnt),
  .adv_stb    (adv_stb),
  .link_stb   (link_stb),
  .pix_stb    (pix_stb)
);

// File: tb/link_frame_sched_bench.sv
module link_frame_sched_bench;

  logic clk = 1'b0;
  logic rst, frame_start, frame_enc, mute, hdmi_mode, adv_en, auth_done;
  logic [31:0] frame_cnt;
  logic        adv_stb, link_stb, pix_stb;
  logic [7:0]  s_cnt;
  logic        s_adv, s_link, s_pix;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] exp_cnt;

  always #10 clk = ~clk;   // 50 MHz

  link_frame_sched u_link_frame_sched (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_enc(frame_enc),
    .mute(mute), .hdmi_mode(hdmi_mode), .adv_en(adv_en), .auth_done(auth_done),
    .frame_cnt(frame_cnt), .adv_stb(adv_stb), .link_stb(link_stb), .pix_stb(pix_stb)
  );

  // narrow instance to reach the wrap quickly
  link_frame_sched #(.CNT_W(8)) u_small (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_enc(frame_enc),
    .mute(mute), .hdmi_mode(hdmi_mode), .adv_en(adv_en), .auth_done(auth_done),
    .frame_cnt(s_cnt), .adv_stb(s_adv), .link_stb(s_link), .pix_stb(s_pix)
  );

  // vector fields: {enc, mute, hdmi, adv, expect_step}
  localparam int NVEC = 14;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1_0_0_0_1,  // R3 encrypted frame
    5'b0_0_0_0_0,  // R3 clear frame, no step
    5'b0_1_0_0_0,  // R4 DVI mute ignored, still clear
    5'b0_1_0_1_1,  // R4 advance-always, DVI, mute ignored
    5'b0_0_0_1_1,  // R4
    5'b0_0_1_1_1,  // R5 HDMI unmuted clear frame
    5'b1_1_1_1_0,  // R6 muted
    5'b0_0_1_1_0,  // R6 after mute, clear frame waits
    5'b1_0_1_1_1,  // R6 resume on encrypted
    5'b0_0_1_1_1,  // R5 normal again
    5'b1_1_1_0_0,  // R6 muted
    5'b1_0_1_0_1,  // R3
    5'b0_0_1_0_0,  // R3
    5'b1_0_0_0_1   // R3
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one frame pulse at a negedge; return one negedge later, outputs updated
  task automatic frame(input logic enc, input logic mu, input logic hd, input logic ad);
    frame_enc = enc; mute = mu; hdmi_mode = hd; adv_en = ad;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    #1;
  endtask

  task automatic auth();
    auth_done = 1'b1;
    @(negedge clk);
    auth_done = 1'b0;
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; frame_start = 0; frame_enc = 0; mute = 0; hdmi_mode = 0;
    adv_en = 0; auth_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(frame_cnt == 0 && !adv_stb && !link_stb && !pix_stb, "R1 reset state",
          {frame_cnt[30:0], adv_stb}, 0);

    // frames before authentication are ignored
    frame(1, 0, 0, 1);
    check(frame_cnt == 0 && !adv_stb, "R1 idle frame", frame_cnt, 0);

    auth();
    frame(0, 0, 0, 1);
    check(frame_cnt == 0 && !adv_stb, "R2 clear frame while armed", frame_cnt, 0);
    frame(1, 1, 1, 1);
    check(frame_cnt == 0 && !adv_stb, "R2 muted frame while armed", frame_cnt, 0);

    // R11: during the frame_start cycle the count is still old
    frame_enc = 1; mute = 0; hdmi_mode = 0; adv_en = 0; frame_start = 1'b1;
    #2;
    check(frame_cnt == 0 && !adv_stb, "R11 no change before edge", frame_cnt, 0);
    @(negedge clk);
    frame_start = 1'b0;
    #1;
    check(frame_cnt == 1 && adv_stb, "R2 first encrypted frame loads 1", frame_cnt, 1);
    @(negedge clk);
    #1;
    check(!adv_stb && frame_cnt == 1, "R11 strobe lasts one cycle", {31'd0, adv_stb}, 0);
    exp_cnt = 1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      frame(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      exp_cnt = exp_cnt + {31'd0, VEC[i][0]};
      check(frame_cnt == exp_cnt && adv_stb == VEC[i][0],
            $sformatf("R3/R4/R5/R6 vector %0d", i), frame_cnt, exp_cnt);
      @(negedge clk);
    end

    // run on to 256, checking both periodic strobes (R7, R8) and the narrow wrap (R10)
    while (exp_cnt < 256) begin
      frame(0, 0, 0, 1);
      exp_cnt++;
      check(frame_cnt == exp_cnt, "R4 count", frame_cnt, exp_cnt);
      check(pix_stb == (exp_cnt % 16 == 0), "R8 pixel strobe", {31'd0, pix_stb}, exp_cnt);
      check(link_stb == (exp_cnt % 128 == 0), "R7 link strobe", {31'd0, link_stb}, exp_cnt);
      if (exp_cnt == 256) begin
        check(s_cnt == 0 && s_adv, "R10 wrap advance", {24'd0, s_cnt}, 0);
        check(!s_link && !s_pix, "R10 no strobe at wrap", {30'd0, s_link, s_pix}, 0);
      end
    end

    // re-authentication clears and re-arms
    auth();
    check(frame_cnt == 0 && s_cnt == 0, "R9 auth clears", frame_cnt, 0);
    frame(0, 0, 0, 1);
    check(frame_cnt == 0 && !adv_stb, "R9 re-armed waits", frame_cnt, 0);
    frame(1, 0, 0, 0);
    check(frame_cnt == 1 && adv_stb, "R9 re-armed loads 1", frame_cnt, 1);
    @(negedge clk);
    // auth and frame together: auth wins
    auth_done = 1'b1;
    frame(1, 0, 0, 1);
    auth_done = 1'b0;
    check(frame_cnt == 0 && !adv_stb, "R9 auth beats frame", frame_cnt, 0);

    summary();
  end

endmodule